// File: doc/BRIEF.md
# Page Translation Cache with Access Check

This block caches recent linear-to-physical page translations for a 32-bit address space with 4 KB pages. It is direct-mapped: the low bits of the linear page number pick one entry. Each entry holds a page tag, a physical page number, the address of the page table entry that produced it, and three attribute bits. These are the combined user-accessible bit, the combined writable bit and a dirty flag.

A lookup is presented for one cycle, and the response appears on registered outputs one cycle later. On a hit the block forms the physical address and judges whether the access is allowed. The judgement uses the write-protect control, the requester's privilege, the cached attributes and the access type. A permitted write to a clean page marks the entry dirty and asks the surrounding walker to update the page table entry in memory. A denied access raises a protection fault with an error code.

The page walk itself and all memory traffic happen outside the block. The walker installs results through a single-cycle fill port. Software-driven maintenance uses the flush-all and single-entry invalidate inputs.

Top module: `tlb_xlate`

## Requirements
- R1: Reset, a flush and an invalidate each mark entries empty by setting the stored tag to all ones. A later lookup of any page held before then misses. A miss drives rsp_hit, rsp_fault, rsp_upd, rsp_err, rsp_paddr, rsp_pte_addr and rsp_pte_mask to zero.
- R2: Linear address bits 16:12 select one of 32 entries. A lookup hits only when the stored tag equals linear bits 31:12. A linear page number of all ones never hits.
- R3: Responses are registered. rsp_valid follows lk_valid one cycle later. On a hit, rsp_paddr is the stored physical page number above the 12-bit page offset of the lookup, and rsp_pte_addr is the stored page table entry address.
- R4: With wp_en=1, an access is denied when a user-level requester (lk_user=1) touches a supervisor page (cached user bit 0), or when a write touches a read-only page (cached writable bit 0). Supervisor writes are included in the second rule.
- R5: With wp_en=0, a supervisor requester is always allowed. A user requester is denied on a supervisor page, or on a write to a read-only page.
- R6: A fetch (lk_fetch=1) is judged as a read whatever lk_write is. It never requests a dirty update, and it reports a read in the error code.
- R7: A permitted write that hits an entry whose dirty flag is 0 raises rsp_upd, and rsp_pte_mask is 0x00000060 (accessed bit 5 and dirty bit 6). It also sets the entry's dirty flag, so an identical write that follows does not raise rsp_upd. rsp_pte_mask is zero whenever rsp_upd is 0.
- R8: A denied hit raises rsp_fault with error code bit 0 = 1 (page present), bit 1 = access was a write and bit 2 = requester was user level. rsp_err is zero without a fault.
- R9: A lookup in the same cycle as flush_all reports a miss.
- R10: A fill writes tag, physical page, entry address and attributes in one cycle, and a lookup on the next cycle sees them. A lookup in the fill's own cycle sees the entry's previous contents.
- R11: When several writes target one entry in a cycle, the priority is flush, then invalidate, then fill for the tag, and fill over the dirty update for the attributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_en | input | 1 | Write-protect control for supervisor writes |
| lk_valid | input | 1 | Lookup request |
| lk_laddr | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is a write |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_user | input | 1 | Requester runs at user level |
| fill_en | input | 1 | Install an entry |
| fill_laddr | input | 32 | Linear address of the installed page |
| fill_pframe | input | 20 | Physical page number to install |
| fill_pte_addr | input | 32 | Address of the page table entry |
| fill_user_ok | input | 1 | Combined user-accessible bit |
| fill_wr_ok | input | 1 | Combined writable bit |
| fill_dirty | input | 1 | Initial dirty flag |
| flush_all | input | 1 | Empty every entry |
| inval_en | input | 1 | Empty one entry |
| inval_laddr | input | 32 | Linear address whose entry is emptied |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address on hit |
| rsp_fault | output | 1 | Protection fault |
| rsp_err | output | 3 | Fault error code |
| rsp_upd | output | 1 | Page table entry update request |
| rsp_pte_addr | output | 32 | Page table entry address on hit |
| rsp_pte_mask | output | 32 | Bits to set in the page table entry |

## Verification
Two pairs of functions can collide in one cycle. The first is a lookup during a flush. The second is a dirty update that races a fill or an invalidate of the same entry. The bench provokes both with directed cycles that drive the two requests together. Its random phase draws addresses from a small pool of aliased pages so such collisions recur. A reference model applies the stated priorities after computing each cycle's response from the pre-edge contents. Each registered response is compared with that model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef struct packed {
    logic us;
    logic rw;
    logic d;
  } acc_t;

  localparam logic [31:0] PTE_SET_MASK = 32'h0000_0060;

  // Permission rule, index = {wp, user, page_us, page_rw, write}
  function automatic logic perm_allow(input logic [4:0] k);
    logic wp, usr, pus, prw, wr;
    wp  = k[4];
    usr = k[3];
    pus = k[2];
    prw = k[1];
    wr  = k[0];
    if (wp)
      perm_allow = !((usr && !pus) || (wr && !prw));
    else if (!usr)
      perm_allow = 1'b1;
    else
      perm_allow = pus && !(wr && !prw);
  endfunction

endpackage

// File: rtl/tlb_perm.sv
module tlb_perm (
  input  logic wp,
  input  logic user,
  input  logic page_us,
  input  logic page_rw,
  input  logic wr,
  output logic allow
);
  import tlb_pkg::*;

  localparam int LUT_N = 32;

  logic [LUT_N-1:0] lut;

  genvar g;
  generate
    for (g = 0; g < LUT_N; g++) begin : g_lut
      assign lut[g] = perm_allow(5'(g));
    end
  endgenerate

  assign allow = lut[{wp, user, page_us, page_rw, wr}];
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int TAG_W  = 20,
  parameter int PPFN_W = 20,
  parameter int PTE_W  = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              inval_en,
  input  logic [IDX_W-1:0]  inval_idx,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PPFN_W-1:0] fill_ppfn,
  input  logic [PTE_W-1:0]  fill_pte,
  input  acc_t              fill_acc,
  input  logic              dset_en,
  input  logic [IDX_W-1:0]  dset_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [PPFN_W-1:0] rd_ppfn,
  output logic [PTE_W-1:0]  rd_pte,
  output acc_t              rd_acc
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  acc_t              acc_q  [ENTRIES];
  logic [PPFN_W-1:0] ppfn_m [ENTRIES];
  logic [PTE_W-1:0]  pte_m  [ENTRIES];

  // Tags live in flops so a flush empties every entry in one cycle
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst || flush)
        tag_q[e] <= '1;
      else if (inval_en && inval_idx == IDX_W'(e))
        tag_q[e] <= '1;
      else if (fill_en && fill_idx == IDX_W'(e))
        tag_q[e] <= fill_tag;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (rst)
        acc_q[e] <= '0;
      else if (fill_en && fill_idx == IDX_W'(e))
        acc_q[e] <= fill_acc;
      else if (dset_en && dset_idx == IDX_W'(e))
        acc_q[e].d <= 1'b1;
    end
  end

  // Payload arrays: single write port, no reset
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ppfn_m[fill_idx] <= fill_ppfn;
      pte_m[fill_idx]  <= fill_pte;
    end
  end

  assign rd_tag  = tag_q[rd_idx];
  assign rd_acc  = acc_q[rd_idx];
  assign rd_ppfn = ppfn_m[rd_idx];
  assign rd_pte  = pte_m[rd_idx];

  assert_inval_empties_R1: assert property (@(posedge clk) disable iff (rst)
    inval_en |=> tag_q[$past(inval_idx)] == '1);

  assert_fill_over_dirty_R11: assert property (@(posedge clk) disable iff (rst)
    (fill_en && dset_en && fill_idx == dset_idx) |=> acc_q[$past(fill_idx)] == $past(fill_acc));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wp_en,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_laddr,
  input  logic                     lk_write,
  input  logic                     lk_fetch,
  input  logic                     lk_user,
  input  logic                     fill_en,
  input  logic [ADDR_W-1:0]        fill_laddr,
  input  logic [ADDR_W-PAGE_W-1:0] fill_pframe,
  input  logic [ADDR_W-1:0]        fill_pte_addr,
  input  logic                     fill_user_ok,
  input  logic                     fill_wr_ok,
  input  logic                     fill_dirty,
  input  logic                     flush_all,
  input  logic                     inval_en,
  input  logic [ADDR_W-1:0]        inval_laddr,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic [ADDR_W-1:0]        rsp_paddr,
  output logic                     rsp_fault,
  output logic [2:0]               rsp_err,
  output logic                     rsp_upd,
  output logic [ADDR_W-1:0]        rsp_pte_addr,
  output logic [ADDR_W-1:0]        rsp_pte_mask
);
  localparam int PFN_W = ADDR_W - PAGE_W;
  localparam int IDX_LO = PAGE_W;
  localparam int IDX_HI = PAGE_W + IDX_W - 1;

  logic [PFN_W-1:0]  lk_pfn;
  logic [IDX_W-1:0]  lk_idx;
  logic [PAGE_W-1:0] lk_off;
  logic [PFN_W-1:0]  rd_tag;
  logic [PFN_W-1:0]  rd_ppfn;
  logic [ADDR_W-1:0] rd_pte;
  acc_t              rd_acc;
  acc_t              fill_acc;
  logic              is_wr, tag_hit, allow, dset;

  assign lk_pfn = lk_laddr[ADDR_W-1:PAGE_W];
  assign lk_idx = lk_laddr[IDX_HI:IDX_LO];
  assign lk_off = lk_laddr[PAGE_W-1:0];
  assign is_wr  = lk_write && !lk_fetch;
  assign fill_acc = '{us: fill_user_ok, rw: fill_wr_ok, d: fill_dirty};

  tlb_store #(
    .TAG_W(PFN_W), .PPFN_W(PFN_W), .PTE_W(ADDR_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(flush_all),
    .inval_en(inval_en), .inval_idx(inval_laddr[IDX_HI:IDX_LO]),
    .fill_en(fill_en), .fill_idx(fill_laddr[IDX_HI:IDX_LO]),
    .fill_tag(fill_laddr[ADDR_W-1:PAGE_W]), .fill_ppfn(fill_pframe),
    .fill_pte(fill_pte_addr), .fill_acc(fill_acc),
    .dset_en(dset), .dset_idx(lk_idx),
    .rd_idx(lk_idx), .rd_tag(rd_tag), .rd_ppfn(rd_ppfn),
    .rd_pte(rd_pte), .rd_acc(rd_acc)
  );

  tlb_perm u_perm (
    .wp(wp_en), .user(lk_user), .page_us(rd_acc.us),
    .page_rw(rd_acc.rw), .wr(is_wr), .allow(allow)
  );

  assign tag_hit = lk_valid && !flush_all && (rd_tag == lk_pfn) && (lk_pfn != '1);
  assign dset    = tag_hit && allow && is_wr && !rd_acc.d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_paddr    <= '0;
      rsp_fault    <= 1'b0;
      rsp_err      <= '0;
      rsp_upd      <= 1'b0;
      rsp_pte_addr <= '0;
      rsp_pte_mask <= '0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= tag_hit;
      rsp_paddr    <= tag_hit ? {rd_ppfn, lk_off} : '0;
      rsp_fault    <= tag_hit && !allow;
      rsp_err      <= (tag_hit && !allow) ? {lk_user, is_wr, 1'b1} : 3'b000;
      rsp_upd      <= dset;
      rsp_pte_addr <= tag_hit ? rd_pte : '0;
      rsp_pte_mask <= dset ? PTE_SET_MASK : '0;
    end
  end

  assert_flush_miss_R9: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && flush_all) |=> (rsp_valid && !rsp_hit));

  assert_allones_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_laddr[ADDR_W-1:PAGE_W] == '1) |=> !rsp_hit);

  assert_fault_code_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_hit && rsp_err[0] && !rsp_upd));

  assert_upd_mask_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_upd |-> (rsp_hit && !rsp_fault && rsp_pte_mask == PTE_SET_MASK));

  assert_fetch_read_R6: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_fetch) |=> (!rsp_upd && !rsp_err[1]));

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0 && rsp_pte_addr == '0 && !rsp_fault));
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_en, lk_valid, lk_write, lk_fetch, lk_user;
  logic [31:0] lk_laddr, fill_laddr, fill_pte_addr, inval_laddr;
  logic [19:0] fill_pframe;
  logic fill_en, fill_user_ok, fill_wr_ok, fill_dirty, flush_all, inval_en;
  logic rsp_valid, rsp_hit, rsp_fault, rsp_upd;
  logic [31:0] rsp_paddr, rsp_pte_addr, rsp_pte_mask;
  logic [2:0] rsp_err;

  int n_tests = 0;
  int n_fail = 0;

  logic [19:0] mtag [32];
  logic [19:0] mpf  [32];
  logic [31:0] mpte [32];
  logic        mus  [32];
  logic        mrw  [32];
  logic        md   [32];

  always #5 clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst(rst), .wp_en(wp_en), .lk_valid(lk_valid), .lk_laddr(lk_laddr),
    .lk_write(lk_write), .lk_fetch(lk_fetch), .lk_user(lk_user),
    .fill_en(fill_en), .fill_laddr(fill_laddr), .fill_pframe(fill_pframe),
    .fill_pte_addr(fill_pte_addr), .fill_user_ok(fill_user_ok), .fill_wr_ok(fill_wr_ok),
    .fill_dirty(fill_dirty), .flush_all(flush_all), .inval_en(inval_en),
    .inval_laddr(inval_laddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
    .rsp_upd(rsp_upd), .rsp_pte_addr(rsp_pte_addr), .rsp_pte_mask(rsp_pte_mask)
  );

  function automatic logic denied(logic wp, logic usr, logic pus, logic prw, logic wr);
    if (wp) return (usr && !pus) || (wr && !prw);
    return usr && (!pus || (wr && !prw));
  endfunction

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_fetch = 0; lk_user = 0; lk_laddr = 0;
    fill_en = 0; fill_laddr = 0; fill_pframe = 0; fill_pte_addr = 0;
    fill_user_ok = 0; fill_wr_ok = 0; fill_dirty = 0;
    flush_all = 0; inval_en = 0; inval_laddr = 0;
  endtask

  task automatic look(logic [31:0] a, logic w, logic u, logic f);
    lk_valid = 1; lk_laddr = a; lk_write = w; lk_user = u; lk_fetch = f;
  endtask

  task automatic fill(logic [31:0] a, logic [19:0] pf, logic [31:0] pte,
                      logic us, logic rw, logic d);
    fill_en = 1; fill_laddr = a; fill_pframe = pf; fill_pte_addr = pte;
    fill_user_ok = us; fill_wr_ok = rw; fill_dirty = d;
  endtask

  task automatic tick(string req);
    logic [19:0] frame;
    logic [4:0]  i;
    logic wr, hit, dn, e_fault, e_upd;
    logic [31:0] e_pa, e_pte, e_mask;
    logic [2:0]  e_err;
    frame = lk_laddr[31:12];
    i = lk_laddr[16:12];
    wr = lk_write && !lk_fetch;
    hit = lk_valid && !flush_all && mtag[i] == frame && frame != 20'hFFFFF;
    dn = denied(wp_en, lk_user, mus[i], mrw[i], wr);
    e_fault = hit && dn;
    e_err = e_fault ? {lk_user, wr, 1'b1} : 3'b000;
    e_upd = hit && !dn && wr && !md[i];
    e_pa = hit ? {mpf[i], lk_laddr[11:0]} : 32'h0;
    e_pte = hit ? mpte[i] : 32'h0;
    e_mask = e_upd ? 32'h60 : 32'h0;
    if (e_upd) md[i] = 1'b1;
    if (fill_en) begin
      mtag[fill_laddr[16:12]] = fill_laddr[31:12];
      mpf[fill_laddr[16:12]]  = fill_pframe;
      mpte[fill_laddr[16:12]] = fill_pte_addr;
      mus[fill_laddr[16:12]]  = fill_user_ok;
      mrw[fill_laddr[16:12]]  = fill_wr_ok;
      md[fill_laddr[16:12]]   = fill_dirty;
    end
    if (inval_en) mtag[inval_laddr[16:12]] = 20'hFFFFF;
    if (flush_all) for (int k = 0; k < 32; k++) mtag[k] = 20'hFFFFF;
    @(posedge clk);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== lk_valid || rsp_hit !== hit || rsp_paddr !== e_pa ||
        rsp_fault !== e_fault || rsp_err !== e_err || rsp_upd !== e_upd ||
        rsp_pte_addr !== e_pte || rsp_pte_mask !== e_mask) begin
      n_fail++;
      $display("FAIL %s: got v%0b h%0b pa%h f%0b e%0h u%0b pte%h m%h exp v%0b h%0b pa%h f%0b e%0h u%0b pte%h m%h",
        req, rsp_valid, rsp_hit, rsp_paddr, rsp_fault, rsp_err, rsp_upd, rsp_pte_addr,
        rsp_pte_mask, lk_valid, hit, e_pa, e_fault, e_err, e_upd, e_pte, e_mask);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 32; k++) begin
      mtag[k] = 20'hFFFFF; mpf[k] = 0; mpte[k] = 0; mus[k] = 0; mrw[k] = 0; md[k] = 0;
    end
    idle();
    wp_en = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state, then empty cache misses
    n_tests++;
    if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_upd !== 0 || rsp_pte_mask !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: got v%0b h%0b exp 0 0", rsp_valid, rsp_hit);
    end
    look(32'h0000_0000, 0, 0, 0); tick("R1");
    // R10: fill, lookup same cycle sees old (miss), next cycle hits
    fill(32'h0000_3000, 20'hABCDE, 32'h1000_0010, 1, 1, 0);
    look(32'h0000_3456, 0, 1, 0); tick("R10");
    look(32'h0000_3456, 0, 1, 0); tick("R3");
    // R7: first write dirty update, second none
    look(32'h0000_3004, 1, 1, 0); tick("R7");
    look(32'h0000_3008, 1, 1, 0); tick("R7");
    // R2: alias with different tag misses
    look(32'h0002_3000, 0, 0, 0); tick("R2");
    // R5 / R4 / R8: supervisor read-only page
    fill(32'h0000_5000, 20'h12345, 32'h2000_0020, 0, 0, 0); tick("R10");
    look(32'h0000_5010, 0, 1, 0); tick("R5");
    look(32'h0000_5010, 1, 0, 0); tick("R5");
    wp_en = 1;
    fill(32'h0000_5000, 20'h12345, 32'h2000_0020, 0, 0, 0); tick("R10");
    look(32'h0000_5010, 1, 0, 0); tick("R4");
    look(32'h0000_5010, 1, 1, 0); tick("R8");
    look(32'h0000_5010, 0, 0, 0); tick("R4");
    // R6: user page read-only, fetch with write flag
    fill(32'h0000_6000, 20'h00066, 32'h3000_0000, 1, 0, 0); tick("R10");
    look(32'h0000_6000, 1, 1, 1); tick("R6");
    look(32'h0000_6000, 1, 1, 0); tick("R8");
    wp_en = 0;
    // R9: flush with lookup in same cycle, then miss
    look(32'h0000_3000, 0, 1, 0); flush_all = 1; tick("R9");
    look(32'h0000_3000, 0, 1, 0); tick("R1");
    // R1: invalidate one entry
    fill(32'h0000_7000, 20'h00077, 32'h4000_0000, 1, 1, 1); tick("R10");
    inval_laddr = 32'h0000_7abc; inval_en = 1; tick("R1");
    look(32'h0000_7000, 0, 1, 0); tick("R1");
    // R11: invalidate beats fill
    fill(32'h0000_8000, 20'h00088, 32'h5000_0000, 1, 1, 0);
    inval_en = 1; inval_laddr = 32'h0000_8000; tick("R11");
    look(32'h0000_8000, 0, 1, 0); tick("R11");
    // R11: fill beats dirty update of same entry
    fill(32'h0000_9000, 20'h00099, 32'h6000_0000, 1, 1, 0); tick("R10");
    look(32'h0000_9000, 1, 1, 0);
    fill(32'h0000_9000, 20'h0009A, 32'h6000_0004, 1, 1, 0); tick("R11");
    look(32'h0000_9000, 1, 1, 0); tick("R11");
    // R2: all-ones page never hits
    fill(32'hFFFF_F000, 20'h000FF, 32'h7000_0000, 1, 1, 1); tick("R10");
    look(32'hFFFF_F123, 0, 0, 0); tick("R2");
    // Random phase over aliased pages
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a;
      a = {13'($urandom % 3), 2'b00, 5'($urandom % 4), 12'($urandom)};
      if ($urandom % 40 == 0) a[31:12] = 20'hFFFFF;
      wp_en = 1'($urandom);
      if ($urandom % 4 != 0) look(a, 1'($urandom), 1'($urandom), ($urandom % 5 == 0));
      if ($urandom % 4 == 0)
        fill({13'($urandom % 3), 2'b00, 5'($urandom % 4), 12'h0}, 20'($urandom),
             $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom % 10 == 0) begin
        inval_en = 1; inval_laddr = {15'h0, 5'($urandom % 4), 12'h0};
      end
      if ($urandom % 60 == 0) flush_all = 1;
      tick("R11");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule